// File: doc/BRIEF.md
# One-Time-Programmable Fuse Register Sequencer

This block is the bus-facing front end of a small one-time-programmable fuse array. Software reaches it through a 32-bit register port: a control word with write-one-to-set and write-one-to-clear aliases, a timing word, a data word and a window of shadow words. Through these registers it runs three kinds of operation. A program operation ORs a data word into one fuse word. A reload copies the whole fuse array into the shadow words. A shadow access reads or writes one shadow word directly.

A program operation starts only after an unlock key has been placed in the upper half of the control word, and the key is used up by the data write that starts the program. Each fuse word can carry a read lock and a write lock. A bad request raises a sticky error flag. While that flag is set, the block refuses every read, program and reload request until software clears it through the clear alias. The fuse array is modelled as behavioural storage inside the block. Program duration comes from the timing word.

Top module: `fuse_seq_top`

## Requirements
- R1: After reset the control word reads 0, the data word reads 0, the timing word reads TIMING_RESET (default 4), and every shadow word reads 0.
- R2: Bus offsets: 0x000 is the control word; 0x004 and 0x008 are its set and clear aliases, and both read back as the control word. A write to 0x000 loads the target address into bits [7:0]. A write to 0x004 ORs its bits [7:0] into the address, and a write to 0x008 clears the address bits where the written value is 1. Control readback layout: address [7:0], busy bit 8, error bit 9, reload bit 10, and 0x3E77 in [31:16] while the key is armed (0 otherwise).
- R3: A write to 0x000 with 0x3E77 in bits [31:16] arms the key, and any other write to 0x000 disarms it. A write to the data word (0x020) while the key is armed, with busy and error both clear, starts a program operation. Busy is then set for timing[7:0]+1 cycles. Any data write accepted while not busy disarms the key. A data write without the key only stores the data.
- R4: When a program operation completes, the data word is ORed into the fuse word at the address latched when the operation started. Control writes made while the operation is running do not change its target.
- R5: A program request to a write-locked word, or to an address of N_WORDS or above, never sets busy, leaves the fuse array unchanged and sets the error flag.
- R6: Writes to the data word while busy is set are ignored.
- R7: Writing 1 to bit 10 of 0x000 or of 0x004 while busy and error are clear starts a reload. Busy and reload then stay set for N_WORDS cycles while every fuse word is copied into its shadow word, and both clear at the end.
- R8: Shadow word i is read at 0x400 + 0x10*i; other offsets read 0. Reading a read-locked word returns 0xBADABADA and sets the error flag.
- R9: A shadow write updates the word unless a reload is in progress or the word is write-locked. In those two cases the word is unchanged and the error flag is set.
- R10: The error flag stays set until 0x008 is written with bit 9 set, and a write to 0x000 does not clear it. While it is set: no program or reload starts, shadow reads return 0xBADABADA, and shadow writes are ignored.
- R11: A reload or program request made while busy is ignored. The running operation completes unchanged, and the reload bit does not become set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for read side effects) |
| bus_addr | input | BUS_AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The program path is exercised with three kinds of address: an unlocked word, a write-locked word and an out-of-range word. This separates a successful program from each of the two rejection paths. The same word is programmed twice with disjoint bit patterns, which shows whether the array merges the data (OR) or overwrites it. A control write made during programming shows whether the latched address is used. Reloads are started from the direct control write and from the set alias, both with and without a colliding shadow write. Requests are also repeated while busy or while the error flag is set, which separates an accepted request from a refused one. A behavioural model compares the read data on every cycle, so the exact busy window lengths are checked as well.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

  localparam logic [15:0] UNLOCK_KEY  = 16'h3E77;
  localparam logic [31:0] POISON_WORD = 32'hBADA_BADA;

  localparam logic [31:0] OFS_CTRL   = 32'h000;
  localparam logic [31:0] OFS_SET    = 32'h004;
  localparam logic [31:0] OFS_CLR    = 32'h008;
  localparam logic [31:0] OFS_TIMING = 32'h010;
  localparam logic [31:0] OFS_DATA   = 32'h020;
  localparam logic [31:0] OFS_WIN    = 32'h400;

  localparam int BIT_BUSY   = 8;
  localparam int BIT_ERR    = 9;
  localparam int BIT_RELOAD = 10;

  typedef enum logic [1:0] {ENG_IDLE, ENG_PROG, ENG_RELOAD} eng_state_t;

  // offset falls on a shadow word of an n-word array
  function automatic logic win_hit(input logic [31:0] a, input int n);
    return (a >= OFS_WIN) && (a < OFS_WIN + 32'(n) * 32'd16) && (a[3:0] == 4'h0);
  endfunction

  function automatic int win_index(input logic [31:0] a);
    logic [31:0] d;
    d = a - OFS_WIN;
    return int'(d >> 4);
  endfunction

  function automatic logic [31:0] pack_ctrl(input logic key, input logic rel,
                                            input logic err, input logic busy,
                                            input logic [7:0] adr);
    return {(key ? UNLOCK_KEY : 16'h0), 5'b0, rel, err, busy, adr};
  endfunction

endpackage

// File: rtl/fuse_ctl_regs.sv
module fuse_ctl_regs
  import fuse_seq_pkg::*;
#(
  parameter logic [31:0] TIMING_RESET = 32'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        wr_set,
  input  logic        wr_clr,
  input  logic        wr_tim,
  input  logic        wr_data,
  input  logic [31:0] wdata,
  input  logic        busy,
  input  logic        err_set,
  input  logic        err_clr,
  output logic [7:0]  addr_q,
  output logic        key_q,
  output logic        err_q,
  output logic [31:0] data_q,
  output logic [31:0] tim_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      key_q  <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
      tim_q  <= TIMING_RESET;
    end else begin
      if (wr_ctrl) begin
        addr_q <= wdata[7:0];
        key_q  <= (wdata[31:16] == UNLOCK_KEY);
      end
      if (wr_set) addr_q <= addr_q | wdata[7:0];
      if (wr_clr) addr_q <= addr_q & ~wdata[7:0];
      if (wr_tim) tim_q <= wdata;
      if (wr_data && !busy) begin
        data_q <= wdata;
        key_q  <= 1'b0;
      end
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_q) && !$past(err_clr)) |-> err_q);

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(data_q));

endmodule

// File: rtl/fuse_op_engine.sv
module fuse_op_engine
  import fuse_seq_pkg::*;
#(
  parameter int N_WORDS = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_go,
  input  logic             reload_go,
  input  logic [IDX_W-1:0] tgt_addr,
  input  logic [7:0]       prog_len,
  output logic             busy,
  output logic             reloading,
  output logic             commit,
  output logic             reload_step,
  output logic [IDX_W-1:0] lat_addr,
  output logic [IDX_W-1:0] reload_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  eng_state_t st;
  logic [7:0] cnt;

  assign busy        = (st != ENG_IDLE);
  assign reloading   = (st == ENG_RELOAD);
  assign commit      = (st == ENG_PROG) && (cnt == 8'd0);
  assign reload_step = reloading;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ENG_IDLE;
      cnt        <= '0;
      lat_addr   <= '0;
      reload_idx <= '0;
    end else begin
      unique case (st)
        ENG_IDLE: begin
          if (reload_go) begin
            st         <= ENG_RELOAD;
            reload_idx <= '0;
          end else if (prog_go) begin
            st       <= ENG_PROG;
            cnt      <= prog_len;
            lat_addr <= tgt_addr;
          end
        end
        ENG_PROG: begin
          if (cnt == 8'd0) st <= ENG_IDLE;
          else             cnt <= cnt - 8'd1;
        end
        ENG_RELOAD: begin
          if (reload_idx == LAST_IDX) st <= ENG_IDLE;
          else                        reload_idx <= reload_idx + 1'b1;
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  assert_lat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ENG_PROG) && $past(st == ENG_PROG)) |-> $stable(lat_addr));

  assert_reload_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reloading) |-> ($past(reload_idx) == LAST_IDX));

endmodule

// File: rtl/fuse_store.sv
module fuse_store #(
  parameter int N_WORDS = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [IDX_W-1:0] lat_addr,
  input  logic [31:0]      prog_data,
  input  logic             reload_step,
  input  logic [IDX_W-1:0] reload_idx,
  input  logic             sh_we,
  input  logic [IDX_W-1:0] sh_widx,
  input  logic [31:0]      sh_wdata,
  input  logic [IDX_W-1:0] sh_ridx,
  output logic [31:0]      sh_rdata
);

  logic [31:0] fuse_q   [N_WORDS];
  logic [31:0] shadow_q [N_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_WORDS; i++) begin
        fuse_q[i]   <= '0;
        shadow_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_WORDS; i++) begin
        if (commit && lat_addr == IDX_W'(i))
          fuse_q[i] <= fuse_q[i] | prog_data;
        if (reload_step && reload_idx == IDX_W'(i))
          shadow_q[i] <= fuse_q[i];
        else if (sh_we && sh_widx == IDX_W'(i))
          shadow_q[i] <= sh_wdata;
      end
    end
  end

  assign sh_rdata = shadow_q[sh_ridx];

endmodule

// File: rtl/fuse_seq_top.sv
module fuse_seq_top
  import fuse_seq_pkg::*;
#(
  parameter int                 N_WORDS      = 16,
  parameter int                 BUS_AW       = 12,
  parameter logic [N_WORDS-1:0] RD_LOCK_MASK = N_WORDS'(16'h0008),
  parameter logic [N_WORDS-1:0] WR_LOCK_MASK = N_WORDS'(16'h0024),
  parameter logic [31:0]        TIMING_RESET = 32'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  logic [31:0] addr32;
  logic wr_ctrl, wr_set, wr_clr, wr_tim, wr_data;
  logic win;
  logic [IDX_W-1:0] win_i;
  logic rd_locked, wr_locked;

  logic [7:0]  addr_q;
  logic        key_q, err_q;
  logic [31:0] data_q, tim_q, sh_rdata;

  logic busy, reloading, commit, reload_step;
  logic [IDX_W-1:0] lat_addr, reload_idx;

  // named events for the assertions
  logic prog_try, tgt_ok, prog_go, prog_bad, reload_go;
  logic poison_rd, sh_wr_bad, sh_wr_ok, err_set, err_clr;

  assign addr32  = 32'(bus_addr);
  assign wr_ctrl = bus_wr && (addr32 == OFS_CTRL);
  assign wr_set  = bus_wr && (addr32 == OFS_SET);
  assign wr_clr  = bus_wr && (addr32 == OFS_CLR);
  assign wr_tim  = bus_wr && (addr32 == OFS_TIMING);
  assign wr_data = bus_wr && (addr32 == OFS_DATA);

  assign win       = win_hit(addr32, N_WORDS);
  assign win_i     = IDX_W'(win_index(addr32));
  assign rd_locked = RD_LOCK_MASK[win_i];
  assign wr_locked = WR_LOCK_MASK[win_i];

  assign prog_try  = wr_data && key_q && !busy && !err_q;
  assign tgt_ok    = (int'(addr_q) < N_WORDS) && !WR_LOCK_MASK[addr_q[IDX_W-1:0]];
  assign prog_go   = prog_try && tgt_ok;
  assign prog_bad  = prog_try && !tgt_ok;
  assign reload_go = (wr_ctrl || wr_set) && bus_wdata[BIT_RELOAD] && !busy && !err_q;
  assign poison_rd = bus_rd && !bus_wr && win && !err_q && rd_locked;
  assign sh_wr_bad = bus_wr && win && !err_q && (reloading || wr_locked);
  assign sh_wr_ok  = bus_wr && win && !err_q && !reloading && !wr_locked;
  assign err_set   = prog_bad || poison_rd || sh_wr_bad;
  assign err_clr   = wr_clr && bus_wdata[BIT_ERR];

  fuse_ctl_regs #(.TIMING_RESET(TIMING_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(wr_ctrl), .wr_set(wr_set), .wr_clr(wr_clr), .wr_tim(wr_tim),
    .wr_data(wr_data), .wdata(bus_wdata), .busy(busy),
    .err_set(err_set), .err_clr(err_clr),
    .addr_q(addr_q), .key_q(key_q), .err_q(err_q), .data_q(data_q), .tim_q(tim_q)
  );

  fuse_op_engine #(.N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .prog_go(prog_go), .reload_go(reload_go),
    .tgt_addr(addr_q[IDX_W-1:0]), .prog_len(tim_q[7:0]),
    .busy(busy), .reloading(reloading), .commit(commit), .reload_step(reload_step),
    .lat_addr(lat_addr), .reload_idx(reload_idx)
  );

  fuse_store #(.N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .commit(commit), .lat_addr(lat_addr), .prog_data(data_q),
    .reload_step(reload_step), .reload_idx(reload_idx),
    .sh_we(sh_wr_ok), .sh_widx(win_i), .sh_wdata(bus_wdata),
    .sh_ridx(win_i), .sh_rdata(sh_rdata)
  );

  always_comb begin
    bus_rdata = '0;
    if (addr32 == OFS_CTRL || addr32 == OFS_SET || addr32 == OFS_CLR)
      bus_rdata = pack_ctrl(key_q, reloading, err_q, busy, addr_q);
    else if (addr32 == OFS_TIMING)
      bus_rdata = tim_q;
    else if (addr32 == OFS_DATA)
      bus_rdata = data_q;
    else if (win)
      bus_rdata = (err_q || rd_locked) ? POISON_WORD : sh_rdata;
  end

  assert_no_start_in_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(err_q));

  assert_key_spent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !reloading) |-> !key_q);

  assert_locked_no_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_bad |=> (!busy && err_q));

  assert_busy_rejects_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !reloading && !commit) |=> !reloading);

endmodule

// File: tb/test_fuse_seq_top.sv
`timescale 1ns/1ps
module test_fuse_seq_top;

  localparam int NW = 16;
  localparam logic [NW-1:0] RDLK = 16'h0008;
  localparam logic [NW-1:0] WRLK = 16'h0024;
  localparam logic [31:0] KEYW = 32'h3E77_0000;
  localparam logic [31:0] POIS = 32'hBADA_BADA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fuse_seq_top #(.N_WORDS(NW), .BUS_AW(12), .RD_LOCK_MASK(RDLK),
                 .WR_LOCK_MASK(WRLK), .TIMING_RESET(32'd4)) i_fuse_seq_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  // ---------------- behavioural reference model ----------------
  int unsigned fz[NW], sh[NW];
  int unsigned m_addr, m_data, m_tim, m_cnt, m_lat, m_ridx;
  bit m_key, m_busy, m_err, m_rel;

  function automatic bit in_win(int unsigned a);
    return a >= 'h400 && a < 'h400 + NW * 16 && (a % 16) == 0;
  endfunction

  function automatic logic [31:0] exp_read(int unsigned a);
    int unsigned i;
    if (a == 0 || a == 4 || a == 8)
      return (m_key ? KEYW : 32'h0) | (32'(m_rel) << 10) | (32'(m_err) << 9)
             | (32'(m_busy) << 8) | m_addr;
    if (a == 'h10) return m_tim;
    if (a == 'h20) return m_data;
    if (in_win(a)) begin
      i = (a - 'h400) / 16;
      return (m_err || RDLK[i]) ? POIS : sh[i];
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    bit ob, oe, orl;
    int unsigned a, d, i;
    if (!rst_n) begin
      foreach (fz[k]) begin fz[k] = 0; sh[k] = 0; end
      m_addr = 0; m_data = 0; m_tim = 4; m_cnt = 0; m_lat = 0; m_ridx = 0;
      m_key = 0; m_busy = 0; m_err = 0; m_rel = 0;
    end else begin
      ob = m_busy; oe = m_err; orl = m_rel;
      if (ob && orl) begin
        sh[m_ridx] = fz[m_ridx];
        if (m_ridx == NW - 1) begin m_busy = 0; m_rel = 0; end
        else m_ridx++;
      end else if (ob) begin
        if (m_cnt == 0) begin fz[m_lat] |= m_data; m_busy = 0; end
        else m_cnt--;
      end
      a = bus_addr; d = bus_wdata;
      if (bus_wr) begin
        if (a == 0) begin
          m_addr = d & 'hFF; m_key = (d[31:16] == 16'h3E77);
        end
        if (a == 4) m_addr = m_addr | (d & 'hFF);
        if (a == 8) begin
          m_addr = m_addr & ~(d & 'hFF);
          if (d[9]) m_err = 0;
        end
        if ((a == 0 || a == 4) && d[10] && !ob && !oe) begin
          m_busy = 1; m_rel = 1; m_ridx = 0;
        end
        if (a == 'h10) m_tim = d;
        if (a == 'h20 && !ob) begin
          m_data = d;
          if (m_key && !oe) begin
            if (m_addr >= NW || WRLK[m_addr]) m_err = 1;
            else begin m_busy = 1; m_cnt = m_tim & 'hFF; m_lat = m_addr; end
          end
          m_key = 0;
        end
        if (in_win(a) && !oe) begin
          i = (a - 'h400) / 16;
          if (orl || WRLK[i]) m_err = 1;
          else sh[i] = d;
        end
      end else if (bus_rd && in_win(a) && !oe) begin
        i = (a - 'h400) / 16;
        if (RDLK[i]) m_err = 1;
      end
    end
  end

  // cycle-by-cycle comparison of the read port against the model
  always @(posedge clk) begin
    logic [31:0] e;
    #2;
    if (rst_n && !done) begin
      e = exp_read(32'(bus_addr));
      n_checks++;
      if (bus_rdata !== e) begin
        n_errors++;
        $display("FAIL R2 cycle compare @%h: actual=%h expected=%h", bus_addr, bus_rdata, e);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    bus_rd = 1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 0; bus_addr = '0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_addr = '0;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    for (int k = 0; k < 200; k++) begin
      peek(12'h000, v);
      if (!v[8]) break;
      cyc++;
    end
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [31:0] v;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    peek(12'h000, v); chk("R1 ctrl", v, 32'h0);
    peek(12'h010, v); chk("R1 timing", v, 32'h4);
    peek(12'h020, v); chk("R1 data", v, 32'h0);
    rd(12'h400, v);   chk("R1 shadow0", v, 32'h0);

    // R2 address field and aliases
    wr(12'h000, 32'h07); peek(12'h000, v); chk("R2 direct", v, 32'h07);
    wr(12'h004, 32'h30); peek(12'h008, v); chk("R2 set alias", v, 32'h37);
    wr(12'h008, 32'h05); peek(12'h004, v); chk("R2 clr alias", v, 32'h32);

    // R3 data without key, then with key
    wr(12'h020, 32'hA5); peek(12'h020, v); chk("R3 plain data", v, 32'hA5);
    peek(12'h000, v); chk("R3 no start without key", v, 32'h32);
    wr(12'h000, KEYW | 32'h1); peek(12'h000, v); chk("R3 key armed", v, 32'h3E77_0001);
    wr(12'h020, 32'hF0);
    peek(12'h000, v); chk("R3 busy set, key spent", v, 32'h0000_0101);
    wr(12'h000, 32'h09);          // R4 retarget attempt during busy
    wr(12'h020, 32'hFFFF);        // R6 ignored
    peek(12'h020, v); chk("R6 data held while busy", v, 32'hF0);
    wait_idle(c);

    // R7 reload via set alias
    wr(12'h004, 32'h400);
    peek(12'h000, v); chk("R7 reload bits", v, 32'h0000_0509);
    wait_idle(c); chk("R7 reload length", 32'(c), 32'd15);
    rd(12'h410, v); chk("R4 latched target", v, 32'hF0);
    rd(12'h490, v); chk("R4 retarget untouched", v, 32'h0);

    // R3 program length from timing, R4 OR merge, R7 direct reload
    wr(12'h010, 32'h2);
    wr(12'h000, KEYW | 32'h1); wr(12'h020, 32'h0F);
    wait_idle(c); chk("R3 busy length", 32'(c), 32'd3);
    wr(12'h000, 32'h400);
    wait_idle(c); chk("R7 direct reload length", 32'(c), 32'd16);
    rd(12'h410, v); chk("R4 OR merge", v, 32'hFF);
    wr(12'h010, 32'h4);

    // R5 write-locked target
    wr(12'h000, KEYW | 32'h2); wr(12'h020, 32'h55);
    peek(12'h000, v); chk("R5 locked: error, no busy", v, 32'h0000_0202);

    // R10 error blocks everything
    wr(12'h000, KEYW); wr(12'h020, 32'h11);
    peek(12'h000, v); chk("R10 no program in error", v, 32'h0000_0200);
    wr(12'h004, 32'h400);
    peek(12'h000, v); chk("R10 no reload in error", v, 32'h0000_0200);
    rd(12'h410, v); chk("R10 poison while error", v, POIS);
    wr(12'h440, 32'h77);
    wr(12'h000, 32'h200);
    peek(12'h000, v); chk("R10 direct write keeps error", v, 32'h0000_0200);
    wr(12'h008, 32'h200);
    peek(12'h000, v); chk("R10 clear alias", v, 32'h0);
    rd(12'h440, v); chk("R10 shadow write ignored", v, 32'h0);

    // R5 out-of-range target
    wr(12'h000, KEYW | 32'h20); wr(12'h020, 32'h1);
    peek(12'h000, v); chk("R5 out of range", v, 32'h0000_0220);
    wr(12'h008, 32'h200);

    // R8 read-locked word, stride
    rd(12'h430, v); chk("R8 read-locked poison", v, POIS);
    peek(12'h000, v); chk("R8 error raised", 32'(v[9]), 32'd1);
    wr(12'h008, 32'h200);
    rd(12'h414, v); chk("R8 misaligned reads 0", v, 32'h0);
    rd(12'h500, v); chk("R8 beyond window reads 0", v, 32'h0);

    // R9 shadow writes
    wr(12'h440, 32'h1234); rd(12'h440, v); chk("R9 shadow write", v, 32'h1234);
    wr(12'h450, 32'hDEAD);
    peek(12'h000, v); chk("R9 locked shadow error", 32'(v[9]), 32'd1);
    wr(12'h008, 32'h200);
    rd(12'h450, v); chk("R9 locked shadow unchanged", v, 32'h0);
    wr(12'h004, 32'h400);
    wr(12'h4F0, 32'h9999);
    wait_idle(c);
    peek(12'h000, v); chk("R9 write during reload error", 32'(v[9]), 32'd1);
    wr(12'h008, 32'h200);
    rd(12'h4F0, v); chk("R9 reload result kept", v, 32'h0);
    rd(12'h440, v); chk("R7 reload overwrites shadow", v, 32'h0);
    rd(12'h420, v); chk("R5 locked fuse not programmed", v, 32'h0);

    // R11 requests while busy
    wr(12'h000, KEYW | 32'h6); wr(12'h020, 32'hC3);
    wr(12'h004, 32'h400);
    wr(12'h000, KEYW | 32'h6);
    wr(12'h020, 32'h3C);
    wait_idle(c);
    peek(12'h000, v); chk("R11 no late reload, key kept", v, 32'h3E77_0006);
    wr(12'h000, 32'h400);
    wait_idle(c);
    rd(12'h460, v); chk("R11 busy data ignored", v, 32'hC3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule